// File: doc/BRIEF.md
# Burst Write-Readback Memory Tester

This block tests external DDR memory through the user-side command and data port of a memory controller. It works in lockstep, one address at a time. It writes one 128-bit burst, reads the same address back and compares the two words. When they agree, it moves to the next burst address and a fresh data pattern. When they differ, it stops there and flags an error. The block drives the command handshake, feeds the write payload as two 64-bit beats, and collects the two returned read beats.

Test patterns come from a 128-bit LFSR. The LFSR steps once after each successful compare, so every address holds different data. Nothing is issued until the controller reports that calibration has finished. After the last address passes, a done flag is raised. On the first mismatch, the failing address, the expected word and the received word are captured for debug.

Top module: `mem_burst_tester`

## Requirements
- R1: No command and no write beat is issued while `calib_done` has not yet been seen high. After reset, `cmd_en`, `wd_wren`, `done` and `error` are all low.
- R2: Each burst's 128-bit payload goes out as two write beats. Beat 0 carries bits [63:0] and beat 1 carries bits [127:64]. `wd_end` is high on beat 1 only.
- R3: A command stays asserted, with a stable address and opcode, until a cycle where `cmd_en` and `cmd_rdy` are both high. A write beat stays asserted, with stable data and `wd_end`, until `wd_rdy` is high.
- R4: `cmd_is_read` is 0 for a write and 1 for a read. The read of a burst is requested only after its write command and both of its write beats have been accepted, and it uses the same address.
- R5: Burst k (counting from 0) uses address k*ADDR_INC.
- R6: Burst 0 uses pattern SEED. Each later pattern is the previous one transformed by next = {p[126:0], p[127]^p[125]^p[100]^p[98]}.
- R7: Read beats are taken only while `rd_valid` is high. A valid beat with `rd_end` low is the low half, and a valid beat with `rd_end` high is the high half, which completes the burst.
- R8: After NUM_BURSTS bursts compare equal, `done` goes high and stays high, and no further commands are issued.
- R9: On a mismatch, `error` goes high and stays high, and no further commands are issued. At the same time, `fail_addr`, `fail_exp` and `fail_got` capture the burst address, the pattern written and the 128-bit word read back. `done` never rises after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Active-low synchronous reset |
| calib_done | input | 1 | Controller calibration finished |
| cmd_en | output | 1 | Command request |
| cmd_is_read | output | 1 | 1 = read command, 0 = write command |
| cmd_addr | output | ADDR_W | Burst address |
| cmd_rdy | input | 1 | Controller accepts command |
| wd_data | output | 64 | Write beat data |
| wd_wren | output | 1 | Write beat valid |
| wd_end | output | 1 | Last write beat of burst |
| wd_rdy | input | 1 | Controller accepts write beat |
| rd_data | input | 64 | Read beat data |
| rd_valid | input | 1 | Read beat valid |
| rd_end | input | 1 | Last read beat of burst |
| done | output | 1 | All bursts passed |
| error | output | 1 | Mismatch detected |
| fail_addr | output | ADDR_W | Address of first mismatch |
| fail_exp | output | 128 | Word written at failing address |
| fail_got | output | 128 | Word read from failing address |

## Verification
A wrong LFSR step or a swapped beat order shows up on the very first write beat that carries the bad pattern. That happens within a few cycles of the burst starting. A broken address increment is visible at the next accepted write command. Losing track of the handshake shows as a command or beat that drops before it is accepted, as a read issued early, or as a read address that differs from the preceding write address. A wrong compare or wrong capture either leaves `done` missing on a clean memory, or leaves `error` and the captured words wrong when a single bit of the high read beat is corrupted.

// File: rtl/mem_burst_tester.sv
module mem_burst_tester #(
  parameter int ADDR_W     = 28,
  parameter int NUM_BURSTS = 1024,
  parameter int ADDR_INC   = 8,
  parameter logic [127:0] SEED = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              calib_done,
  output logic              cmd_en,
  output logic              cmd_is_read,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_rdy,
  output logic [63:0]       wd_data,
  output logic              wd_wren,
  output logic              wd_end,
  input  logic              wd_rdy,
  input  logic [63:0]       rd_data,
  input  logic              rd_valid,
  input  logic              rd_end,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [127:0]      fail_exp,
  output logic [127:0]      fail_got
);
  localparam int CNT_W = $clog2(NUM_BURSTS + 1);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RDC, S_RDW, S_CMP, S_DONE, S_ERR} state_t;

  state_t             st;
  logic [127:0]       pat, got;
  logic [ADDR_W-1:0]  addr;
  logic [CNT_W-1:0]   idx;
  logic [1:0]         beat;
  logic               wcmd_ok;

  function automatic logic [127:0] lfsr_next(input logic [127:0] v);
    return {v[126:0], v[127] ^ v[125] ^ v[100] ^ v[98]};
  endfunction

  assign cmd_en      = (st == S_WR && !wcmd_ok) || st == S_RDC;
  assign cmd_is_read = (st == S_RDC);
  assign cmd_addr    = addr;
  assign wd_wren     = (st == S_WR) && beat != 2'd2;
  assign wd_end      = (beat == 2'd1);
  assign wd_data     = beat[0] ? pat[127:64] : pat[63:0];
  assign done        = (st == S_DONE);
  assign error       = (st == S_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pat       <= SEED;
      got       <= '0;
      addr      <= '0;
      idx       <= '0;
      beat      <= '0;
      wcmd_ok   <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_got  <= '0;
    end else begin
      case (st)
        S_IDLE: if (calib_done) st <= S_WR;
        S_WR: begin
          if (cmd_en && cmd_rdy) wcmd_ok <= 1'b1;
          if (wd_wren && wd_rdy) beat <= beat + 2'd1;
          if (wcmd_ok && beat == 2'd2) begin
            st      <= S_RDC;
            wcmd_ok <= 1'b0;
            beat    <= '0;
          end
        end
        S_RDC: if (cmd_rdy) st <= S_RDW;
        S_RDW: if (rd_valid) begin
          if (rd_end) begin
            got[127:64] <= rd_data;
            st          <= S_CMP;
          end else begin
            got[63:0] <= rd_data;
          end
        end
        S_CMP: begin
          if (got != pat) begin
            st        <= S_ERR;
            fail_addr <= addr;
            fail_exp  <= pat;
            fail_got  <= got;
          end else if (idx == CNT_W'(NUM_BURSTS - 1)) begin
            st <= S_DONE;
          end else begin
            st   <= S_WR;
            idx  <= idx + 1'b1;
            addr <= addr + ADDR_W'(ADDR_INC);
            pat  <= lfsr_next(pat);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mem_burst_tester_chk.sv
module mem_burst_tester_chk #(
  parameter int ADDR_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              calib_done,
  input logic              cmd_en,
  input logic              cmd_is_read,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_rdy,
  input logic [63:0]       wd_data,
  input logic              wd_wren,
  input logic              wd_end,
  input logic              wd_rdy,
  input logic              done,
  input logic              error,
  input logic [ADDR_W-1:0] fail_addr
);
  logic       calib_seen, wcmd_seen;
  logic [1:0] wbeats;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      calib_seen <= 1'b0;
      wcmd_seen  <= 1'b0;
      wbeats     <= '0;
    end else begin
      if (calib_done) calib_seen <= 1'b1;
      if (cmd_en && cmd_rdy && cmd_is_read) begin
        wcmd_seen <= 1'b0;
        wbeats    <= '0;
      end else begin
        if (cmd_en && cmd_rdy) wcmd_seen <= 1'b1;
        if (wd_wren && wd_rdy && wbeats != 2'd3) wbeats <= wbeats + 2'd1;
      end
    end
  end

  a_r1_calib_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en || wd_wren) |-> (calib_seen || calib_done));
  a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && !cmd_rdy) |=> (cmd_en && $stable(cmd_addr) && $stable(cmd_is_read)));
  a_r3_wd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_wren && !wd_rdy) |=> (wd_wren && $stable(wd_data) && $stable(wd_end)));
  a_r4_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && cmd_is_read) |-> (wbeats == 2'd2 && wcmd_seen));
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !cmd_en));
  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> (error && !done && !cmd_en && $stable(fail_addr)));
endmodule

bind mem_burst_tester mem_burst_tester_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mem_burst_tester_tb.sv
module mem_burst_tester_tb_top;
  localparam int AW = 12, NB = 8, INC = 8, INJ = 5;
  localparam logic [127:0] SEED = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;

  logic clk = 0, rst_n = 0, calib_done = 0;
  logic cmd_en, cmd_is_read, cmd_rdy = 0, wd_wren, wd_end, wd_rdy = 0;
  logic rd_valid = 0, rd_end = 0, done, error;
  logic [AW-1:0] cmd_addr, fail_addr;
  logic [63:0] wd_data, rd_data = '0;
  logic [127:0] fail_exp, fail_got;

  always #4 clk = ~clk;

  mem_burst_tester #(.ADDR_W(AW), .NUM_BURSTS(NB), .ADDR_INC(INC), .SEED(SEED)) dut_i (.*);

  int errors = 0, checks = 0;
  logic [127:0] pats [0:NB];
  logic [127:0] mem [0:15];
  int cyc = 0, inject = 0, k_wr = 0, beats_seen = 0, wcmd_seen = 0, cmd_after = 0;
  logic [3:0] rd_ptr = 0;
  logic [2:0] rd_tmr = 0;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    cmd_rdy <= (cyc % 3) != 0;
    wd_rdy  <= (cyc % 4) != 1;
    rd_valid <= 0; rd_end <= 0;
    if (cmd_en && cmd_rdy && cmd_is_read) begin rd_ptr <= cmd_addr[6:3]; rd_tmr <= 3'd5; end
    if (wd_wren && wd_rdy) begin
      if (wd_end) mem[cmd_addr[6:3]][127:64] <= wd_data;
      else        mem[cmd_addr[6:3]][63:0]   <= wd_data;
    end
    if (rd_tmr != 0) begin
      rd_tmr <= rd_tmr - 3'd1;
      if (rd_tmr == 3'd3) begin rd_valid <= 1; rd_data <= mem[rd_ptr][63:0]; end
      if (rd_tmr == 3'd1) begin
        rd_valid <= 1; rd_end <= 1;
        rd_data <= mem[rd_ptr][127:64] ^ ((inject != 0 && rd_ptr == INJ) ? 64'd1 : 64'd0);
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (!calib_done) check(!cmd_en && !wd_wren, "R1 gate", {cmd_en, wd_wren}, 0);
    if (done || error) if (cmd_en) cmd_after++;
    if (wd_wren && wd_rdy) begin
      check(wd_end == (beats_seen == 1), "R2 wd_end", wd_end, beats_seen == 1);
      check(wd_data == (beats_seen == 1 ? pats[k_wr][127:64] : pats[k_wr][63:0]), "R6 pattern beat",
            wd_data, beats_seen == 1 ? pats[k_wr][127:64] : pats[k_wr][63:0]);
      beats_seen++;
    end
    if (cmd_en && cmd_rdy) begin
      check(cmd_addr == AW'(k_wr * INC), "R5 address", cmd_addr, k_wr * INC);
      if (cmd_is_read) begin
        check(beats_seen == 2 && wcmd_seen == 1, "R4 read order", beats_seen, 2);
        k_wr++; beats_seen = 0; wcmd_seen = 0;
      end else wcmd_seen++;
    end
  end

  task automatic run(input int inj);
    inject = inj; rst_n = 0; calib_done = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1; k_wr = 0; beats_seen = 0; wcmd_seen = 0; cmd_after = 0;
    @(negedge clk);
    check(!cmd_en && !wd_wren && !done && !error, "R1 reset", {cmd_en, wd_wren, done, error}, 0);
    repeat (20) @(negedge clk);
    calib_done = 1;
    for (int i = 0; i < 5000 && !done && !error; i++) @(negedge clk);
    if (!done && !error) check(0, "watchdog", 0, 1);
    repeat (30) @(negedge clk);
    check(cmd_after == 0, "R8/R9 no command after end", cmd_after, 0);
  endtask

  initial begin
    pats[0] = SEED;
    for (int i = 1; i <= NB; i++)
      pats[i] = {pats[i-1][126:0], pats[i-1][127] ^ pats[i-1][125] ^ pats[i-1][100] ^ pats[i-1][98]};
    run(0);
    check(done && !error, "R8 done", {done, error}, 2);
    check(k_wr == NB, "R8 burst count", k_wr, NB);
    check(pats[1] != pats[0], "R6 pattern changes", pats[1], pats[0]);
    run(1);
    check(error && !done, "R9 error", {error, done}, 2);
    check(fail_addr == AW'(INJ * INC), "R9 fail_addr", fail_addr, INJ * INC);
    check(fail_exp == pats[INJ], "R9 fail_exp", fail_exp, pats[INJ]);
    check(fail_got == (pats[INJ] ^ (128'd1 << 64)), "R7 R9 fail_got", fail_got, pats[INJ] ^ (128'd1 << 64));
    check(k_wr == INJ + 1, "R9 stops at failing burst", k_wr, INJ + 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule